// File: doc/BRIEF.md
# Flash program/erase status responder

This block models the device side of a parallel NOR-style flash part during its internal write operations. A host drives active-low chip enable, output enable and write enable strobes together with an address, a byte of write data and an erase select. A qualified write strobe starts either a program of one byte or an erase of the whole (small) register array. The internal operation is modelled as a countdown in clock cycles, and while it runs the active-low ready/busy output is held low.

While an operation is in progress, read accesses do not return array contents. They return a status byte. Bit 7 is the data-polling bit: during a program it is the complement of bit 7 of the byte being written, and during an erase it is 0. Bit 6 inverts after every read access, so a host can poll by comparing successive reads. Once the countdown ends, reads return true array data again and bit 6 freezes.

Writes are refused in several cases. The strobes may be in an inhibiting combination, or a strobe pulse may be shorter than the glitch filter width. The part may still be inside the power-on lockout window, the supply-low input may be asserted, or an operation may already be running.

Top module: `flash_status_resp`

## Requirements
- R1: A read access (ce_n=0, oe_n=0) while ready returns the stored byte at the address. Whenever there is no read access, rdata is 8'h00. After reset every location holds 8'hFF.
- R2: During a program, a read of any address returns bit 7 equal to the complement of bit 7 of the written byte, with bits 5..0 equal to 0. When the program ends, the addressed location holds the written byte.
- R3: During an erase (erase_sel=1 at start), reads return bit 7 = 0 and bits 5..0 = 0. When the erase ends, every location reads 8'hFF.
- R4: An internal toggle flag appears on rdata bit 6 during busy reads. It inverts at the clock edge where a read access ends while the block is busy, and it never changes while the block is ready.
- R5: rdy_busy goes to 0 in the cycle after the start edge. It stays 0 for exactly PROG_CYCLES cycles for a program, or ERASE_CYCLES cycles for an erase, and then returns to 1.
- R6: No operation starts while oe_n=0, ce_n=1 or we_n=1. A write is qualified only by ce_n=0, we_n=0 and oe_n=1.
- R7: A qualified write must hold for FILT_CYCLES consecutive cycles to start an operation. Shorter pulses are ignored, and a longer pulse starts only one operation.
- R8: For LOCK_CYCLES cycles after reset release, no operation starts.
- R9: No operation starts while supply_low=1.
- R10: A write that qualifies while busy is ignored. It neither changes the array nor extends the busy time.
- R11: After reset, rdy_busy=1 and rdata=8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Access address |
| wdata | input | 8 | Byte to program |
| erase_sel | input | 1 | 1 selects erase of the whole array for the write |
| supply_low | input | 1 | Supply-low indication, blocks writes |
| rdata | output | 8 | Read data or status byte |
| rdy_busy | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench drives write pulses of random length around the filter width, mixed with reads at random addresses and idle gaps. Its reference model is checked every cycle, which separates a pulse that is one cycle too short from one that just qualifies, and a program status from an erase status. Directed cases start writes with output enable low, during lockout, with supply low and during busy, and confirm through later reads that the array is unchanged. Back-to-back busy reads show bit 6 alternating, and reads before and after an operation show it frozen while ready.

// File: rtl/flash_status_pkg.sv
// Shared types for the flash status responder.
package flash_status_pkg;
    // Kind of internal operation currently held by the busy timer.
    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;
endpackage

// File: rtl/fsr_strobe_filter.sv
// Glitch filter on the write strobe. Emits a single-cycle fire when the
// qualified write condition has held FILT_CYCLES consecutive cycles.
// Assumes FILT_CYCLES >= 1; the counter saturates so one pulse fires once.
module fsr_strobe_filter #(
    parameter int FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    output logic fire
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Fire on the cycle that completes the required run length.
    assign fire = wr_act && (cnt == CW'(FILT_CYCLES - 1));

    // Count consecutive active cycles, saturating at the filter width.
    always_ff @(posedge clk) begin
        if (!rst_n || !wr_act) begin
            cnt <= '0;
        end else if (cnt != CW'(FILT_CYCLES)) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r7_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/fsr_lockout.sv
// Power-on lockout: done rises LOCK_CYCLES cycles after reset release and
// then stays high until the next reset.
module fsr_lockout #(
    parameter int LOCK_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(LOCK_CYCLES));

    // Count up after reset until the lockout window is over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fsr_busy_timer.sv
// Busy countdown for program or erase. A start loads the length of the
// chosen operation; busy then stays high for exactly that many cycles.
// Assumes start is only raised while idle.
module fsr_busy_timer
    import flash_status_pkg::*;
#(
    parameter int PROG_CYCLES  = 12,
    parameter int ERASE_CYCLES = 40
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  op_kind_e op_in,
    output logic     busy,
    output op_kind_e op_q
);
    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Load on start, count down while busy, drop busy after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            op_q <= OP_PROG;
        end else if (start) begin
            busy <= 1'b1;
            op_q <= op_in;
            cnt  <= (op_in == OP_ERASE) ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    a_r5_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> busy);
    a_r10_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/fsr_read_path.sv
// Small register array plus the read multiplexer. While ready, reads give
// the array; while busy, they give the status byte with the polling bit
// and the toggle bit. Assumes DEPTH is a power of two.
module fsr_read_path
    import flash_status_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  op_kind_e          op,
    input  logic              rd_act,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];
    logic       last_d7;
    logic       tgl;
    logic       rd_q;

    // Array update: reset and erase fill with ones, program writes a byte.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_en) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (prog_en) begin
            mem[waddr] <= wdata;
        end
    end

    // Remember bit 7 of the last programmed byte for data polling.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_d7 <= 1'b0;
        else if (prog_en) last_d7 <= wdata[7];
    end

    // Toggle flag inverts when a read access ends during busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl  <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (rd_q && !rd_act && busy) tgl <= ~tgl;
        end
    end

    // Output select: idle bus, array data or status byte.
    always_comb begin
        if (!rd_act)            rdata = 8'h00;
        else if (!busy)         rdata = mem[raddr];
        else if (op == OP_ERASE) rdata = {1'b0, tgl, 6'b0};
        else                    rdata = {~last_d7, tgl, 6'b0};
    end

    a_r4_frozen_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tgl));
    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |-> (rdata == 8'h00));
endmodule

// File: rtl/flash_status_resp.sv
// Top of the flash status responder. Qualifies write strobes, applies the
// lockout and supply inhibit rules, starts the busy timer and routes reads
// through the array/status multiplexer. All inputs are assumed synchronous
// to clk.
module flash_status_resp
    import flash_status_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int ADDR_W       = $clog2(DEPTH),
    parameter int FILT_CYCLES  = 3,
    parameter int LOCK_CYCLES  = 20,
    parameter int PROG_CYCLES  = 12,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              erase_sel,
    input  logic              supply_low,
    output logic [7:0]        rdata,
    output logic              rdy_busy
);
    logic     wr_act, rd_act, fire, lock_done, busy, start;
    op_kind_e op_q, op_in;

    assign wr_act   = !ce_n && !we_n && oe_n;
    assign rd_act   = !ce_n && !oe_n;
    assign op_in    = erase_sel ? OP_ERASE : OP_PROG;
    assign start    = fire && !busy && lock_done && !supply_low;
    assign rdy_busy = !busy;

    fsr_strobe_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .fire(fire));

    fsr_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .done(lock_done));

    fsr_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in),
        .busy(busy), .op_q(op_q));

    fsr_read_path #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .prog_en(start && !erase_sel), .erase_en(start && erase_sel),
        .waddr(addr), .wdata(wdata), .busy(busy), .op(op_q),
        .rd_act(rd_act), .raddr(addr), .rdata(rdata));

    a_r6_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || ce_n || we_n) |=> !$rose(busy));
    a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_done |=> !$rose(busy));
    a_r9_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !$rose(busy));
endmodule

// File: tb/flash_status_resp_tb.sv
module flash_status_resp_tb;
    localparam int DEPTH = 16, AW = 4, FILT = 3, LOCK = 20, PROG = 12, ERASE = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1, oe_n = 1, we_n = 1, erase_sel = 0, supply_low = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic rdy_busy;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_status_resp #(.DEPTH(DEPTH), .FILT_CYCLES(FILT), .LOCK_CYCLES(LOCK),
        .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .erase_sel(erase_sel), .supply_low(supply_low),
        .rdata(rdata), .rdy_busy(rdy_busy));

    // Reference model state, stepped from the requirements.
    int m_fcnt = 0, m_lcnt = 0, m_bcnt = 0;
    bit m_busy = 0, m_er = 0, m_d7 = 0, m_tgl = 0, m_rdq = 0;
    logic [7:0] m_mem [DEPTH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fcnt = 0; m_lcnt = 0; m_bcnt = 0; m_busy = 0; m_er = 0;
            m_d7 = 0; m_tgl = 0; m_rdq = 0;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        end else begin
            bit wa, fire, lock, start, rd;
            wa = !ce_n && !we_n && oe_n;
            fire = wa && (m_fcnt == FILT - 1);
            if (!wa) m_fcnt = 0; else if (m_fcnt < FILT) m_fcnt++;
            lock = (m_lcnt == LOCK);
            if (!lock) m_lcnt++;
            start = fire && !m_busy && lock && !supply_low;
            rd = !ce_n && !oe_n;
            if (m_rdq && !rd && m_busy) m_tgl = !m_tgl;
            m_rdq = rd;
            if (start) begin
                m_busy = 1; m_er = erase_sel;
                m_bcnt = (erase_sel ? ERASE : PROG) - 1;
                if (erase_sel) for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
                else begin m_mem[addr] = wdata; m_d7 = wdata[7]; end
            end else if (m_busy) begin
                if (m_bcnt == 0) m_busy = 0; else m_bcnt--;
            end
        end
    end

    function automatic logic [7:0] exp_rdata();
        if (ce_n || oe_n) return 8'h00;
        if (!m_busy) return m_mem[addr];
        if (m_er) return {1'b0, m_tgl, 6'b0};
        return {~m_d7, m_tgl, 6'b0};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R1, R2, R3, R4, R5).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R5 rdy_busy", {7'b0, rdy_busy}, {7'b0, !m_busy});
            if (ce_n || oe_n || !m_busy) check("R1 rdata", rdata, exp_rdata());
            else if (m_er) check("R3 erase status", rdata, exp_rdata());
            else check("R2_R4 program status", rdata, exp_rdata());
        end
    end

    task automatic hold(bit c, bit o, bit w, logic [AW-1:0] a, logic [7:0] d, bit e, int n);
        ce_n = c; oe_n = o; we_n = w; addr = a; wdata = d; erase_sel = e;
        repeat (n) @(posedge clk);
        #1;
    endtask
    task automatic idle(int n); hold(1, 1, 1, addr, wdata, 0, n); endtask
    task automatic wr(logic [AW-1:0] a, logic [7:0] d, bit e, int len);
        hold(0, 1, 0, a, d, e, len); idle(1);
    endtask
    task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        @(negedge clk); v = rdata;
        @(posedge clk); #1; idle(1);
    endtask
    task automatic wait_ready();
        int g = 0;
        while (!rdy_busy && g < 1000) begin @(posedge clk); #1; g++; end
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int n;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        @(negedge clk);
        check("R11 reset rdy", {7'b0, rdy_busy}, 8'h01);
        check("R11 reset rdata", rdata, 8'h00);
        // R8: write during lockout ignored
        @(posedge clk); #1;
        wr(4'h2, 8'h12, 0, FILT + 1);
        check("R8 lockout rdy", {7'b0, rdy_busy}, 8'h01);
        idle(LOCK);
        rd(4'h2, v); check("R8 lockout array", v, 8'hFF);
        // R7: pulse one cycle short
        wr(4'h3, 8'h33, 0, FILT - 1);
        check("R7 short pulse", {7'b0, rdy_busy}, 8'h01);
        rd(4'h3, v); check("R7 short array", v, 8'hFF);
        // R6: output enable low during write
        hold(0, 0, 0, 4'h3, 8'h44, 0, FILT + 2); idle(1);
        check("R6 oe low", {7'b0, rdy_busy}, 8'h01);
        rd(4'h3, v); check("R6 array", v, 8'hFF);
        // R9: supply low
        supply_low = 1; wr(4'h3, 8'h55, 0, FILT + 2); supply_low = 0;
        check("R9 supply low", {7'b0, rdy_busy}, 8'h01);
        rd(4'h3, v); check("R9 array", v, 8'hFF);
        // R2/R4: program then polled reads; R10 write while busy
        wr(4'h5, 8'h8A, 0, FILT);
        check("R5 busy after start", {7'b0, rdy_busy}, 8'h00);
        rd(4'h9, v); rd(4'h5, v2);
        check("R2 poll bit7", {7'b0, v[7]}, 8'h00);
        check("R4 toggle", {7'b0, v[6] ^ v2[6]}, 8'h01);
        wr(4'h6, 8'h66, 0, FILT);
        wait_ready();
        rd(4'h5, v); check("R2 stored", v, 8'h8A);
        rd(4'h6, v); check("R10 ignored", v, 8'hFF);
        rd(4'h5, v); rd(4'h5, v2); check("R4 frozen", v2, v);
        // R3: erase
        wr(4'h0, 8'h00, 1, FILT + 1);
        rd(4'h5, v); check("R3 erase bit7", v & 8'hBF, 8'h00);
        wait_ready();
        rd(4'h5, v); check("R3 erased", v, 8'hFF);
        // Random mix
        for (int k = 0; k < 600; k++) begin
            n = $urandom_range(0, 9);
            if (n < 3) wr(AW'($urandom), 8'($urandom), ($urandom_range(0, 7) == 0),
                          $urandom_range(1, FILT + 2));
            else if (n < 8) rd(AW'($urandom), v);
            else if (n == 8) begin
                supply_low = $urandom_range(0, 1);
                wr(AW'($urandom), 8'($urandom), 0, FILT);
                supply_low = 0;
            end else idle($urandom_range(1, 6));
        end
        wait_ready();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule